// File: doc/BRIEF.md
# Single-Byte SPI Master

This block is a serial peripheral master that moves exactly one 8-bit word per start command. Software talks to it through a byte-wide register window on a plain synchronous bus. It loads a transmit byte, sets the start bit and then waits for the interrupt. The block shifts the byte out on MOSI and shifts a byte in from MISO. It places the received byte in a receive register and raises its interrupt. The block has no queue, so every further byte needs a fresh load and a fresh start.

The serial clock is the system clock divided by 4 × (divisor + 1). The divisor is latched when a transfer starts. Clock idle level, the edge on which data is sampled, bit order and an internal loopback path are set through the mode register. Chip selects are driven outside this block. The register bus is a control path with no back-pressure. Every access finishes in the cycle it is presented, and a read has its side effect at the clock edge that ends that cycle.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register in the window reads 0, and sck, mosi and irq are all low.
- R2: The register offsets are 0 mode, 1 receive data, 2 transmit data, 3 control, 4 status and 6 divisor. Mode keeps only its low five bits. Transmit data and divisor read back exactly what was written. Control and offsets 5 and 7 always read 0.
- R3: Writing a value with bit 0 set to offset 3 starts a transfer when the port is enabled (mode bit 0x08) and the block is idle. Status bit 0x02 (busy) then reads 1 in the very next cycle.
- R4: While mode bit 0x08 is 0, sck stays at its idle level, mosi stays low and start commands are ignored, so status stays 0.
- R5: A start written while busy is ignored. So are writes to transmit data or divisor during a transfer: the byte in flight and its timing do not change.
- R6: With divisor d latched at the start, sck first leaves its idle level 2(d+1) cycles after the start edge. irq rises 32(d+1)+1 cycles after that edge.
- R7: When irq rises, status reads 0x03. One cycle later busy has cleared and status reads 0x01.
- R8: Mode bit 0x02 sets the idle level of sck (0 low, 1 high). sck is at that level before and after every transfer.
- R9: When mode bit 0x10 is 1, data is sampled on the leading sck edge and changes on the trailing edge (SPI mode 0/2). When it is 0, data changes on the leading edge and is sampled on the trailing edge (mode 1/3).
- R10: When mode bit 0x04 is 0, the word is sent and received MSB first. When it is 1, it is sent and received LSB first.
- R11: When mode bit 0x01 is 1, the receiver takes the outgoing bit stream in place of miso, so the received byte equals the transmitted byte whatever miso does.
- R12: A completed transfer sets status bit 0x01 and irq. Reading offset 1 clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Received byte ready |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench issues a second start and then rewrites transmit data and divisor while a byte is in flight. A design that restarted, or that read the divisor live, would finish at the wrong cycle or return the wrong byte. It counts cycles from the start edge to the first sck edge and to irq, and it checks the single cycle in which ready and busy are both set. An off-by-one in the divider or in the busy tail would show up as a miscount. A bench slave sampling on the proper edge runs all eight combinations of sampling edge, clock polarity and bit order. An inverted sense of the sampling bit, or a swapped bit order, would corrupt the bytes in both directions.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  // register offsets in the byte window
  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_RXD  = 3'd1;
  localparam logic [2:0] OFS_TXD  = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam logic [2:0] OFS_DIV  = 3'd6;

  // mode register bit indices
  localparam int MODE_W  = 5;
  localparam int MB_LOOP = 0;
  localparam int MB_CPOL = 1;
  localparam int MB_LSB  = 2;
  localparam int MB_EN   = 3;
  localparam int MB_LEAD = 4;
endpackage

// File: rtl/spim_sck_gen.sv
`timescale 1ns/1ps
module spim_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // half sck period = 2*(div+1) system cycles
  assign lim  = {div, 1'b1};
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) run |-> (cnt <= lim)); // R6
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         tick,
  input  logic         lead,
  input  logic         rx_in,
  output logic         active,
  output logic         phase,
  output logic         tx_bit,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic [W-1:0]  tx_sh;
  logic [EW-1:0] edge_q;
  logic          last, samp, shft;

  assign last = (edge_q == EW'(EDGES - 1));
  // even edge index = leading edge, odd = trailing
  assign samp = tick && active && (lead ? !edge_q[0] : edge_q[0]);
  assign shft = tick && active && (lead ? edge_q[0] : (!edge_q[0] && (edge_q != '0)));
  assign tx_bit = tx_sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_word <= '0;
      edge_q  <= '0;
      phase   <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= tick && active && last;
      if (start) begin
        tx_sh  <= load;
        edge_q <= '0;
        phase  <= 1'b0;
        active <= 1'b1;
      end else begin
        if (tick && active) begin
          phase  <= !phase;
          edge_q <= edge_q + 1'b1;
          if (last) active <= 1'b0;
        end
        if (shft) tx_sh <= {tx_sh[W-2:0], 1'b0};
        if (samp) rx_word <= {rx_word[W-2:0], rx_in};
      end
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !active); // R5
  AST_PHASE_HOME: assert property (@(posedge clk) disable iff (!rst_n) done |-> !phase); // R8
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic [MODE_W-1:0] mode_q;
  logic [WORD_W-1:0] tx_q, rx_q, tx_load, rx_fix, rx_word;
  logic [DIV_W-1:0]  div_q, div_run;
  logic              busy_q, rdy_q, done_d;
  logic              wr, rd, go, tick, active, phase, tx_bit, done_p, rx_in;

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;
  assign go = wr && (bus_addr == OFS_CTRL) && bus_wdata[0] && mode_q[MB_EN] && !busy_q;

  // bit-order steering on both paths
  for (genvar i = 0; i < WORD_W; i++) begin : g_order
    assign tx_load[i] = mode_q[MB_LSB] ? tx_q[WORD_W-1-i]    : tx_q[i];
    assign rx_fix[i]  = mode_q[MB_LSB] ? rx_word[WORD_W-1-i] : rx_word[i];
  end

  assign rx_in = mode_q[MB_LOOP] ? tx_bit : miso;
  assign sck   = mode_q[MB_CPOL] ^ (mode_q[MB_EN] & phase);
  assign mosi  = mode_q[MB_EN] & tx_bit;
  assign irq   = rdy_q;

  spim_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(active), .div(div_run), .tick(tick)
  );

  spim_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(go), .load(tx_load), .tick(tick),
    .lead(mode_q[MB_LEAD]), .rx_in(rx_in), .active(active), .phase(phase),
    .tx_bit(tx_bit), .done(done_p), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      div_q   <= '0;
      div_run <= '0;
      busy_q  <= 1'b0;
      rdy_q   <= 1'b0;
      done_d  <= 1'b0;
    end else begin
      if (wr && bus_addr == OFS_MODE) mode_q <= bus_wdata[MODE_W-1:0];
      if (wr && bus_addr == OFS_TXD)  tx_q   <= bus_wdata;
      if (wr && bus_addr == OFS_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
      done_d <= done_p;
      if (go) begin
        busy_q  <= 1'b1;
        div_run <= div_q;
      end else if (done_d) begin
        busy_q  <= 1'b0;
      end
      if (done_p) begin
        rx_q  <= rx_fix;
        rdy_q <= 1'b1;
      end else if (rd && bus_addr == OFS_RXD) begin
        rdy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE: bus_rdata = WORD_W'(mode_q);
      OFS_RXD:  bus_rdata = rx_q;
      OFS_TXD:  bus_rdata = tx_q;
      OFS_STAT: bus_rdata = WORD_W'({busy_q, rdy_q});
      OFS_DIV:  bus_rdata = WORD_W'(div_q);
      default:  bus_rdata = '0;
    endcase
  end

  AST_BUSY_START:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) |-> $past(wr && bus_addr == OFS_CTRL && bus_wdata[0])); // R3
  AST_OFF_NOSTART: assert property (@(posedge clk) disable iff (!rst_n) (!mode_q[MB_EN] && !busy_q) |=> !busy_q); // R4
  AST_RDY_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdy_q) |-> busy_q); // R7
  AST_BUSY_TAIL:   assert property (@(posedge clk) disable iff (!rst_n) $rose(rdy_q) |=> !busy_q); // R7
  AST_IDLE_SCK:    assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> (sck == mode_q[MB_CPOL])); // R8
  AST_RD_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) (rd && bus_addr == OFS_RXD && !done_p) |=> !irq); // R12
endmodule

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  initial forever #2.5 clk = ~clk;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // all bus tasks are entered at a falling edge and leave at one
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // polls status; n counts rising edges since the start edge
  task automatic wait_irq(input int n0, input bit idle, output int ni, output int ns);
    int n = n0;
    ns = -1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd4;
    while (1) begin
      #1;
      if (ns < 0 && sck != idle) ns = n;
      if (irq || n > 20000) break;
      @(negedge clk);
      n++;
    end
    ni = n;
  endtask

  task automatic slave(input logic [7:0] sb, input bit se, input bit lsb, output logic [7:0] got);
    logic [7:0] seq, gs;
    seq = lsb ? rev8(sb) : sb;
    gs = '0;
    if (se) miso = seq[7];
    for (int e = 0; e < 16; e++) begin
      @(sck);
      if (se) begin
        if (e % 2 == 0) gs = {gs[6:0], mosi};
        else if (e < 15) miso = seq[6 - e/2];
      end else begin
        if (e % 2 == 0) miso = seq[7 - e/2];
        else gs = {gs[6:0], mosi};
      end
    end
    got = lsb ? rev8(gs) : gs;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(sck == 1'b0, "R1", "sck", sck, 0);
    chk(mosi == 1'b0, "R1", "mosi", mosi, 0);
    chk(irq == 1'b0, "R1", "irq", irq, 0);
    for (int a = 0; a < 8; a++) begin
      bus_read(3'(a), v);
      chk(v == 8'h00, "R1", "register", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_write(3'd0, 8'hF5); bus_read(3'd0, v); chk(v == 8'h15, "R2", "mode mask", v, 8'h15);
    bus_write(3'd2, 8'hA5); bus_read(3'd2, v); chk(v == 8'hA5, "R2", "tx", v, 8'hA5);
    bus_write(3'd6, 8'h37); bus_read(3'd6, v); chk(v == 8'h37, "R2", "divisor", v, 8'h37);
    bus_write(3'd3, 8'hFE); bus_read(3'd3, v); chk(v == 8'h00, "R2", "control", v, 0);
    bus_read(3'd5, v); chk(v == 8'h00, "R2", "offset 5", v, 0);
    bus_read(3'd7, v); chk(v == 8'h00, "R2", "offset 7", v, 0);
    bus_write(3'd0, 8'h00); bus_write(3'd6, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    bus_write(3'd0, 8'h02);
    #1 chk(sck == 1'b1, "R8", "idle high", sck, 1);
    chk(mosi == 1'b0, "R4", "mosi off", mosi, 0);
    bus_write(3'd3, 8'h01);
    repeat (3) @(negedge clk);
    bus_read(3'd4, v); chk(v == 8'h00, "R4", "start ignored", v, 0);
    #1 chk(sck == 1'b1, "R4", "sck held", sck, 1);
    bus_write(3'd0, 8'h00);
  endtask

  task automatic t_loop_timing(input int d, input logic [7:0] tx);
    int ni, ns;
    logic [7:0] v;
    miso = 1'b1;
    bus_write(3'd0, 8'h19);
    bus_write(3'd6, 8'(d));
    bus_write(3'd2, tx);
    bus_write(3'd3, 8'h01);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd4;
    #1 chk(bus_rdata == 8'h02, "R3", "busy after start", bus_rdata, 2);
    wait_irq(0, 1'b0, ni, ns);
    chk(ns == 2*(d+1), "R6", "first sck edge", ns, 2*(d+1));
    chk(ni == 32*(d+1)+1, "R6", "irq latency", ni, 32*(d+1)+1);
    chk(bus_rdata == 8'h03, "R7", "status at irq", bus_rdata, 3);
    @(negedge clk); #1;
    chk(bus_rdata == 8'h01, "R7", "busy tail", bus_rdata, 1);
    bus_en = 1'b0;
    @(negedge clk);
    bus_read(3'd1, v); chk(v == tx, "R11", "loopback byte", v, tx);
    #1 chk(irq == 1'b0, "R12", "irq cleared", irq, 0);
    bus_read(3'd4, v); chk(v == 8'h00, "R12", "status cleared", v, 0);
    miso = 1'b0;
  endtask

  task automatic t_restart();
    int ni, ns;
    logic [7:0] v;
    bus_write(3'd0, 8'h19);
    bus_write(3'd6, 8'd1);
    bus_write(3'd2, 8'h96);
    bus_write(3'd3, 8'h01);
    bus_write(3'd3, 8'h01);
    bus_write(3'd2, 8'h00);
    bus_write(3'd6, 8'd5);
    wait_irq(3, 1'b0, ni, ns);
    chk(ni == 65, "R5", "latency despite restart", ni, 65);
    chk(bus_rdata == 8'h03, "R7", "status at irq", bus_rdata, 3);
    bus_en = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(3'd1, v); chk(v == 8'h96, "R5", "byte in flight", v, 8'h96);
    bus_read(3'd6, v); chk(v == 8'h05, "R6", "divisor kept", v, 5);
  endtask

  task automatic t_mode(input bit se, input bit cpol, input bit lsb, input int d, input logic [7:0] tx, input logic [7:0] sb);
    int ni, ns;
    logic [7:0] v, got;
    bus_write(3'd0, {3'b000, se, 1'b1, lsb, cpol, 1'b0});
    bus_write(3'd6, 8'(d));
    bus_write(3'd2, tx);
    #1 chk(sck == cpol, "R8", "idle before", sck, cpol);
    fork
      begin
        bus_write(3'd3, 8'h01);
        wait_irq(0, cpol, ni, ns);
        bus_en = 1'b0;
      end
      slave(sb, se, lsb, got);
    join
    @(negedge clk);
    chk(got == tx, "R9 R10", "mosi byte", got, tx);
    bus_read(3'd1, v);
    chk(v == sb, "R9 R10", "miso byte", v, sb);
    #1 chk(sck == cpol, "R8", "idle after", sck, cpol);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_loop_timing(0, 8'h3C);
    t_loop_timing(3, 8'hC5);
    t_restart();
    for (int k = 0; k < 8; k++)
      t_mode(k[2], k[1], k[0], k % 2, 8'h4B ^ 8'(k), 8'hD2 ^ 8'(k << 4));
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule